// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block gathers the interrupt sources of a 10/100 network controller into a single status register. Each bit of that register has a matching mask bit. A single interrupt line is asserted when any unmasked source is active. The sources do not all clear the same way:

- The receive-overrun and transmit-queue-empty bits are latched and clear through a write-one acknowledge.
- The receive-ready and transmit-done bits report whether a packet-number queue holds anything.
- The allocation bit reflects the outcome of the most recent buffer allocation.
- The composite error bit clears only once every cause behind it has been serviced.

Two 4-deep packet-number queues live inside the block. The receive queue takes the numbers of good frames and is drained by a release strobe. The transmit-done queue takes the numbers of completed transmissions and is drained by acknowledging the transmit-done bit. The MAC, the allocator and the statistics counters sit outside the block and reach it only as pulses and levels. Software reaches it through a small register port:

| Address | Read | Write |
|---|---|---|
| 0 | status | acknowledge |
| 1 | mask | mask |
| 2 | control | control |
| 3 | transmit-done queue head | no effect |
| 4 | receive queue head | no effect |
| 5 | error cause register | no effect |

Reads are combinational from the address. A read strobe at address 5 has a side effect, described in R8.

Top module: `nic_irq_unit`

## Requirements
- R1: After reset, the following all read zero and `irq` is low: status, mask and control. Status bit positions are: 0 receive-ready, 1 transmit-done, 2 transmit-empty, 3 allocation-ok, 4 receive-overrun, 5 error. Bits 7:6 always read zero.
- R2: The frame is not queued and status bit 4 latches when `rx_end` is seen with any of these conditions:
  - a length above 2048;
  - `rx_nomem` high;
  - control bit 4 (discard) set;
  - the receive queue full.
  A length of exactly 2048 is accepted. Bit 4 clears only on a write to address 0 with bit 4 set.
- R3: Status bit 0 is high exactly while the receive queue holds a packet number. A good frame pushes `rx_num`, and `rx_release` pops the head. Address 4 reads {empty flag in bit 7, zero, head number in bits 5:0}.
- R4: Status bit 1 is high exactly while the transmit-done queue holds a number. `tx_complete` pushes `tx_num`. A write to address 0 with bit 1 set pops one entry. Address 3 reads the head in the same layout as address 4.
- R5: Status bit 2 is set in every cycle that `tx_q_empty` is high. Once set, it stays set until it is acknowledged (bit 2 written to address 0) while `tx_q_empty` is low.
- R6: Status bit 3 is set by `alloc_done` with `alloc_fail` low. It is cleared by `alloc_done` with `alloc_fail` high, or by `alloc_req`. When both arrive together, the completion wins.
- R7: Status bit 5 is the OR of three cause flags, read at address 5 in bits 0 (link), 1 (rollover) and 2 (transmit fatal). Each cause is set only when its enable in control bits 0, 1 or 2 is high.
  - The link cause is set by `link_change`.
  - The rollover cause is set by `cnt_rollover`.
  - The transmit-fatal cause is set by any bit of `tx_fatal` (late collision, sixteen collisions, SQE error, lost carrier).
- R8: Each cause clears only when it is serviced:
  - link: a control write with bit 0 low;
  - rollover: a read strobe at address 5;
  - transmit fatal: a control write with bit 3 (transmit enable) high.
  Any `tx_fatal` bit clears control bit 3, which drives `tx_enable`. A new event wins over a clear in the same cycle.
- R9: `irq` equals the OR of (status AND mask), registered. It changes one clock after the status or mask change that causes it.
- R10: An acknowledge write of zero changes nothing. Acknowledge bits 0, 3 and 5 are ignored.
- R11: Each queue holds 4 entries in first-in first-out order. A push to a full transmit-done queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at address 5 only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rx_end | input | 1 | Receive frame finished |
| rx_len | input | 12 | Length of the finished frame in bytes |
| rx_nomem | input | 1 | Buffer allocation for the frame failed |
| rx_num | input | 6 | Packet number of the finished frame |
| rx_release | input | 1 | Host releases the head receive packet |
| tx_q_empty | input | 1 | Transmit queue empty level |
| tx_complete | input | 1 | A transmission finished |
| tx_num | input | 6 | Packet number of the finished transmission |
| alloc_req | input | 1 | Allocation request begins processing |
| alloc_done | input | 1 | Allocation finished |
| alloc_fail | input | 1 | Finished allocation failed |
| link_change | input | 1 | Link state changed |
| cnt_rollover | input | 1 | Statistics counter rolled over |
| tx_fatal | input | 4 | Fatal transmit errors: late collision, 16 collisions, SQE, lost carrier |
| tx_enable | output | 1 | Transmit enable (control bit 3) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check several local rules:
- the queue occupancy bound and the dropping of pushes into a full queue;
- the hold of the overrun latch until it is acknowledged;
- the set of the transmit-empty bit from its level;
- the set and clear of the allocation bit;
- the immunity of the receive bit to acknowledges;
- the clearing and enable gating of each error cause;
- the silence of `irq` under an all-zero mask.

Some behaviour only the directed scenarios can show, because it spans several operations or depends on data:
- first-in first-out order across a full queue;
- the exact 2048-byte length boundary;
- the latch-then-acknowledge sequence that yields a real-time empty reading;
- the servicing sequence for each error cause.

The scenarios also sweep every mask bit against each source while comparing `irq` with a reference model.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int NUM_W   = 6;
  localparam int LEN_W   = 12;
  localparam int N_CAUSE = 3;
  localparam int N_FATAL = 4;

  localparam int B_RX    = 0;
  localparam int B_TXD   = 1;
  localparam int B_TXE   = 2;
  localparam int B_ALLOC = 3;
  localparam int B_OVR   = 4;
  localparam int B_ERR   = 5;

  localparam int K_LINK  = 0;
  localparam int K_ROLL  = 1;
  localparam int K_TXERR = 2;

  localparam int C_LINK  = 0;
  localparam int C_TXENA = 3;
  localparam int CTRL_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_MASK   = 3'd1,
    A_CTRL   = 3'd2,
    A_TXHEAD = 3'd3,
    A_RXHEAD = 3'd4,
    A_CAUSE  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic discard;
    logic tx_ena;
    logic txerr_en;
    logic roll_en;
    logic link_en;
  } ctrl_t;
endpackage

// File: rtl/nic_irq_pnq.sv
module nic_irq_pnq #(
  parameter int DEPTH = 4,
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NUM_W-1:0] push_num,
  input  logic             pop,
  output logic [NUM_W-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [NUM_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = slot_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wptr_q == PTR_W'(s));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[s] <= push_num;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wptr_q)));
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/nic_irq_errsrc.sv
module nic_irq_errsrc
  import nic_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] event_in,
  input  logic [N_CAUSE-1:0] enable,
  input  logic [N_CAUSE-1:0] service,
  output logic [N_CAUSE-1:0] cause,
  output logic               err
);
  assign err = |cause;

  for (genvar k = 0; k < N_CAUSE; k++) begin : g_cause
    logic set_k, cause_d, cause_q;
    assign set_k = event_in[k] & enable[k];

    always_comb begin
      cause_d = cause_q;
      if (service[k]) cause_d = 1'b0;
      if (set_k)      cause_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= 1'b0;
      else        cause_q <= cause_d;
    end

    assign cause[k] = cause_q;

    p_service_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (service[k] && !(event_in[k] && enable[k])) |=> !cause[k]);
    p_enable_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause[k] && !enable[k]) |=> !cause[k]);
    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (event_in[k] && enable[k]) |=> cause[k]);
  end
endmodule

// File: rtl/nic_irq_regif.sv
module nic_irq_regif
  import nic_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [DATA_W-1:0]  stat,
  input  logic [NUM_W-1:0]   txd_head,
  input  logic               txd_empty,
  input  logic [NUM_W-1:0]   rx_head,
  input  logic               rx_empty,
  input  logic [N_CAUSE-1:0] cause,
  input  logic               fatal_any,
  output logic [DATA_W-1:0]  mask,
  output ctrl_t              ctrl,
  output logic               ack_txd,
  output logic               ack_txe,
  output logic               ack_ovr,
  output logic [N_CAUSE-1:0] service
);
  logic [DATA_W-1:0] mask_q, mask_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              wr_stat, wr_mask, wr_ctrl;

  assign wr_stat = wr && (addr == A_STAT);
  assign wr_mask = wr && (addr == A_MASK);
  assign wr_ctrl = wr && (addr == A_CTRL);

  assign ack_txd = wr_stat & wdata[B_TXD];
  assign ack_txe = wr_stat & wdata[B_TXE];
  assign ack_ovr = wr_stat & wdata[B_OVR];

  assign service[K_LINK]  = wr_ctrl & ~wdata[C_LINK];
  assign service[K_ROLL]  = rd && (addr == A_CAUSE);
  assign service[K_TXERR] = wr_ctrl & wdata[C_TXENA];

  always_comb begin
    mask_d = mask_q;
    ctrl_d = ctrl_q;
    if (wr_mask) mask_d = wdata;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    if (fatal_any) ctrl_d.tx_ena = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      mask_q <= mask_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign mask = mask_q;
  assign ctrl = ctrl_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:   rdata = stat;
      A_MASK:   rdata = mask_q;
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_TXHEAD: begin
        rdata[NUM_W-1:0] = txd_head;
        rdata[DATA_W-1]  = txd_empty;
      end
      A_RXHEAD: begin
        rdata[NUM_W-1:0] = rx_head;
        rdata[DATA_W-1]  = rx_empty;
      end
      A_CAUSE:  rdata[N_CAUSE-1:0] = cause;
      default:  rdata = '0;
    endcase
  end

  p_fatal_drops_txena_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_any |=> !ctrl.tx_ena);
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_irq_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  parameter int MAX_LEN = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               rx_end,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               rx_nomem,
  input  logic [NUM_W-1:0]   rx_num,
  input  logic               rx_release,
  input  logic               tx_q_empty,
  input  logic               tx_complete,
  input  logic [NUM_W-1:0]   tx_num,
  input  logic               alloc_req,
  input  logic               alloc_done,
  input  logic               alloc_fail,
  input  logic               link_change,
  input  logic               cnt_rollover,
  input  logic [N_FATAL-1:0] tx_fatal,
  output logic               tx_enable,
  output logic               irq
);
  logic [DATA_W-1:0]  stat, mask;
  ctrl_t              ctrl;
  logic               ack_txd, ack_txe, ack_ovr;
  logic [N_CAUSE-1:0] service, cause, err_events, err_enables;
  logic               err, fatal_any;
  logic [NUM_W-1:0]   txd_head, rx_head;
  logic               txd_empty, txd_full, rx_empty, rx_full;
  logic               rx_bad, rx_push, ovr_set;
  logic               ovr_q, ovr_d, txe_q, txe_d, alloc_q, alloc_d, irq_q, irq_d;

  assign fatal_any = |tx_fatal;
  assign rx_bad    = (rx_len > LEN_W'(MAX_LEN)) | rx_nomem | ctrl.discard | rx_full;
  assign rx_push   = rx_end & ~rx_bad;
  assign ovr_set   = rx_end & rx_bad;

  nic_irq_pnq #(.DEPTH(Q_DEPTH), .NUM_W(NUM_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_num(rx_num),
    .pop(rx_release), .head(rx_head), .empty(rx_empty), .full(rx_full));

  nic_irq_pnq #(.DEPTH(Q_DEPTH), .NUM_W(NUM_W)) u_txdq (
    .clk(clk), .rst_n(rst_n), .push(tx_complete), .push_num(tx_num),
    .pop(ack_txd), .head(txd_head), .empty(txd_empty), .full(txd_full));

  assign err_events[K_LINK]   = link_change;
  assign err_events[K_ROLL]   = cnt_rollover;
  assign err_events[K_TXERR]  = fatal_any;
  assign err_enables[K_LINK]  = ctrl.link_en;
  assign err_enables[K_ROLL]  = ctrl.roll_en;
  assign err_enables[K_TXERR] = ctrl.txerr_en;

  nic_irq_errsrc u_err (
    .clk(clk), .rst_n(rst_n), .event_in(err_events), .enable(err_enables),
    .service(service), .cause(cause), .err(err));

  nic_irq_regif u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .stat(stat),
    .txd_head(txd_head), .txd_empty(txd_empty),
    .rx_head(rx_head), .rx_empty(rx_empty), .cause(cause),
    .fatal_any(fatal_any), .mask(mask), .ctrl(ctrl),
    .ack_txd(ack_txd), .ack_txe(ack_txe), .ack_ovr(ack_ovr),
    .service(service));

  always_comb begin
    ovr_d = ovr_q;
    if (ack_ovr) ovr_d = 1'b0;
    if (ovr_set) ovr_d = 1'b1;

    txe_d = txe_q;
    if (ack_txe)    txe_d = 1'b0;
    if (tx_q_empty) txe_d = 1'b1;

    alloc_d = alloc_q;
    if (alloc_req)  alloc_d = 1'b0;
    if (alloc_done) alloc_d = ~alloc_fail;
  end

  always_comb begin
    stat          = '0;
    stat[B_RX]    = ~rx_empty;
    stat[B_TXD]   = ~txd_empty;
    stat[B_TXE]   = txe_q;
    stat[B_ALLOC] = alloc_q;
    stat[B_OVR]   = ovr_q;
    stat[B_ERR]   = err;
    irq_d         = |(stat & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      txe_q   <= 1'b0;
      alloc_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ovr_q   <= ovr_d;
      txe_q   <= txe_d;
      alloc_q <= alloc_d;
      irq_q   <= irq_d;
    end
  end

  assign irq       = irq_q;
  assign tx_enable = ctrl.tx_ena;

  p_ovr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_OVR] && !(reg_wr && reg_addr == A_STAT && reg_wdata[B_OVR])) |=> stat[B_OVR]);
  p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_len > LEN_W'(MAX_LEN)) |=> stat[B_OVR]);
  p_txe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q_empty |=> stat[B_TXE]);
  p_alloc_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && !alloc_fail) |=> stat[B_ALLOC]);
  p_alloc_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_done) |=> !stat[B_ALLOC]);
  p_rx_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_RX] && !rx_release) |=> stat[B_RX]);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);
  p_hi_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat[DATA_W-1:B_ERR+1] == '0);
endmodule

// File: tb/nic_irq_unit_tb.sv
`timescale 1ns/100ps
module nic_irq_unit_tb;
  logic       clk, rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       rx_end, rx_nomem, rx_release;
  logic [11:0] rx_len;
  logic [5:0] rx_num, tx_num;
  logic       tx_q_empty, tx_complete;
  logic       alloc_req, alloc_done, alloc_fail;
  logic       link_change, cnt_rollover;
  logic [3:0] tx_fatal;
  logic       tx_enable, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  nic_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_end(rx_end), .rx_len(rx_len), .rx_nomem(rx_nomem), .rx_num(rx_num),
    .rx_release(rx_release), .tx_q_empty(tx_q_empty), .tx_complete(tx_complete),
    .tx_num(tx_num), .alloc_req(alloc_req), .alloc_done(alloc_done),
    .alloc_fail(alloc_fail), .link_change(link_change), .cnt_rollover(cnt_rollover),
    .tx_fatal(tx_fatal), .tx_enable(tx_enable), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rx_frame(input logic [5:0] n, input logic [11:0] len, input logic nomem);
    rx_end = 1'b1; rx_num = n; rx_len = len; rx_nomem = nomem;
    tick();
    rx_end = 1'b0; rx_nomem = 1'b0;
  endtask

  task automatic rx_pop();
    rx_release = 1'b1;
    tick();
    rx_release = 1'b0;
  endtask

  task automatic tx_done(input logic [5:0] n);
    tx_complete = 1'b1; tx_num = n;
    tick();
    tx_complete = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); chk("R1 status after reset", d, 8'h00);
    rd(3'd1, d); chk("R1 mask after reset", d, 8'h00);
    rd(3'd2, d); chk("R1 control after reset", d, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    rx_frame(6'd5, 12'd100, 1'b0);
    rd(3'd0, d); chk("R3 rx bit after good frame", d, 8'h01);
    rd(3'd4, d); chk("R3 rx head", d, 8'h05);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R10 ack of rx bit ignored", d, 8'h01);
    rx_pop();
    rd(3'd0, d); chk("R3 rx bit after release", d, 8'h00);
    rd(3'd4, d); chk("R3 rx queue empty flag", d[7:6], 2'b10);
  endtask

  task automatic t_ovr();
    logic [7:0] d;
    rx_frame(6'd9, 12'd3000, 1'b0);
    rd(3'd0, d); chk("R2 long frame overrun, not queued", d, 8'h10);
    wr(3'd0, 8'h00);
    rd(3'd0, d); chk("R10 zero ack keeps overrun", d, 8'h10);
    wr(3'd0, 8'h10);
    rd(3'd0, d); chk("R2 overrun acked", d, 8'h00);
    rx_frame(6'd9, 12'd2048, 1'b0);
    rd(3'd0, d); chk("R2 length 2048 accepted", d, 8'h01);
    rx_pop();
    rx_frame(6'd9, 12'd64, 1'b1);
    rd(3'd0, d); chk("R2 nomem overrun", d, 8'h10);
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h10);
    rx_frame(6'd9, 12'd64, 1'b0);
    rd(3'd0, d); chk("R2 discard overrun", d, 8'h10);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h10);
    rd(3'd0, d); chk("R2 cleared after discard", d, 8'h00);
  endtask

  task automatic t_rx_full();
    logic [7:0] d;
    for (int i = 1; i <= 4; i++) rx_frame(6'(i), 12'd60, 1'b0);
    rd(3'd0, d); chk("R11 rx queue full, no overrun yet", d, 8'h01);
    rx_frame(6'd33, 12'd60, 1'b0);
    rd(3'd0, d); chk("R2 full rx queue overrun", d, 8'h11);
    for (int i = 1; i <= 4; i++) begin
      rd(3'd4, d); chk("R11 rx order", d, 8'(i));
      rx_pop();
    end
    rd(3'd4, d); chk("R11 rx drained", d[7:6], 2'b10);
    wr(3'd0, 8'h10);
  endtask

  task automatic t_txdone();
    logic [7:0] d;
    tx_done(6'd7);
    tx_done(6'd9);
    rd(3'd0, d); chk("R4 tx-done bit", d, 8'h02);
    rd(3'd3, d); chk("R4 tx-done head first", d, 8'h07);
    wr(3'd0, 8'h02);
    rd(3'd3, d); chk("R4 ack pops one", d, 8'h09);
    wr(3'd0, 8'h02);
    rd(3'd0, d); chk("R4 tx-done bit clears when empty", d, 8'h00);
    rd(3'd3, d); chk("R4 empty flag", d[7:6], 2'b10);
    for (int i = 10; i <= 14; i++) tx_done(6'(i));
    for (int i = 10; i <= 13; i++) begin
      rd(3'd3, d); chk("R11 tx-done order, 5th dropped", d, 8'(i));
      wr(3'd0, 8'h02);
    end
    rd(3'd0, d); chk("R11 tx-done drained", d, 8'h00);
  endtask

  task automatic t_txe();
    logic [7:0] d;
    tx_q_empty = 1'b1;
    tick();
    rd(3'd0, d); chk("R5 empty latched", d, 8'h04);
    wr(3'd0, 8'h04);
    rd(3'd0, d); chk("R5 ack while empty re-sets", d, 8'h04);
    tx_q_empty = 1'b0;
    tick(); tick();
    rd(3'd0, d); chk("R5 stays latched", d, 8'h04);
    wr(3'd0, 8'h04);
    rd(3'd0, d); chk("R5 ack clears when not empty", d, 8'h00);
  endtask

  task automatic t_alloc();
    logic [7:0] d;
    alloc_done = 1'b1; alloc_fail = 1'b0; tick(); alloc_done = 1'b0;
    rd(3'd0, d); chk("R6 alloc ok", d, 8'h08);
    wr(3'd0, 8'h08);
    rd(3'd0, d); chk("R10 ack of alloc ignored", d, 8'h08);
    alloc_req = 1'b1; tick(); alloc_req = 1'b0;
    rd(3'd0, d); chk("R6 cleared by next request", d, 8'h00);
    alloc_req = 1'b1; alloc_done = 1'b1; tick(); alloc_req = 1'b0; alloc_done = 1'b0;
    rd(3'd0, d); chk("R6 completion wins over request", d, 8'h08);
    alloc_done = 1'b1; alloc_fail = 1'b1; tick(); alloc_done = 1'b0; alloc_fail = 1'b0;
    rd(3'd0, d); chk("R6 cleared by failure", d, 8'h00);
  endtask

  task automatic t_err();
    logic [7:0] d;
    link_change = 1'b1; tick(); link_change = 1'b0;
    rd(3'd0, d); chk("R7 disabled link cause ignored", d, 8'h00);
    wr(3'd2, 8'h01);
    link_change = 1'b1; tick(); link_change = 1'b0;
    rd(3'd0, d); chk("R7 link sets error", d, 8'h20);
    rd(3'd5, d); chk("R7 link cause bit", d, 8'h01);
    wr(3'd0, 8'h20);
    rd(3'd0, d); chk("R10 ack of error ignored", d, 8'h20);
    wr(3'd2, 8'h00);
    rd(3'd0, d); chk("R8 link cleared by enable low", d, 8'h00);
    wr(3'd2, 8'h02);
    cnt_rollover = 1'b1; tick(); cnt_rollover = 1'b0;
    rd(3'd5, d); chk("R7 rollover cause bit", d, 8'h02);
    reg_rd = 1'b1; reg_addr = 3'd5; tick(); reg_rd = 1'b0;
    rd(3'd0, d); chk("R8 rollover cleared by counter read", d, 8'h00);
    wr(3'd2, 8'h0C);
    chk("R8 tx_enable set by control", {7'b0, tx_enable}, 8'h01);
    tx_fatal = 4'b0010; tick(); tx_fatal = 4'b0000;
    rd(3'd5, d); chk("R7 fatal cause bit", d, 8'h04);
    rd(3'd2, d); chk("R8 fatal clears tx enable", d, 8'h04);
    chk("R8 tx_enable pin low", {7'b0, tx_enable}, 8'h00);
    wr(3'd2, 8'h0C);
    rd(3'd0, d); chk("R8 fatal cleared by tx enable", d, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic sweep(input logic [7:0] exp_stat);
    logic [7:0] d;
    logic       prev;
    rd(3'd0, d); chk("R9 model status", d, exp_stat);
    prev = irq;
    for (int b = 0; b <= 6; b++) begin
      logic [7:0] m;
      m = (b == 6) ? 8'h00 : 8'(1 << b);
      wr(3'd1, m);
      chk("R9 irq one clock late", {7'b0, irq}, {7'b0, prev});
      tick();
      prev = |(exp_stat & m);
      chk("R9 irq equals masked status", {7'b0, irq}, {7'b0, prev});
    end
  endtask

  task automatic t_mask();
    logic [7:0] d;
    logic [7:0] es;
    es = 8'h00; sweep(es);
    rx_frame(6'd3, 12'd80, 1'b0);          es[0] = 1'b1; sweep(es);
    tx_done(6'd4);                          es[1] = 1'b1; sweep(es);
    tx_q_empty = 1'b1; tick(); tx_q_empty = 1'b0; es[2] = 1'b1; sweep(es);
    alloc_done = 1'b1; tick(); alloc_done = 1'b0; es[3] = 1'b1; sweep(es);
    rx_frame(6'd5, 12'd4000, 1'b0);         es[4] = 1'b1; sweep(es);
    wr(3'd2, 8'h01);
    link_change = 1'b1; tick(); link_change = 1'b0; es[5] = 1'b1; sweep(es);
    wr(3'd1, 8'h00);
    rx_pop();
    wr(3'd0, 8'h16);
    alloc_req = 1'b1; tick(); alloc_req = 1'b0;
    wr(3'd2, 8'h00);
    rd(3'd0, d); chk("R9 all sources cleared", d, 8'h00);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rx_end = 0; rx_len = '0; rx_nomem = 0; rx_num = '0; rx_release = 0;
    tx_q_empty = 0; tx_complete = 0; tx_num = '0;
    alloc_req = 0; alloc_done = 0; alloc_fail = 0;
    link_change = 0; cnt_rollover = 0; tx_fatal = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_rx();
    t_ovr();
    t_rx_full();
    t_txdone();
    t_txe();
    t_alloc();
    t_err();
    t_mask();
    done = 1;
    summary();
    $finish;
  end
endmodule